// File: doc/BRIEF.md
# Memory Power Mode Sequencer

This block is the digital mode controller of a memory power subsystem built from one switching regulator, one termination regulator and a set of linear regulator controllers. It has three modes: OFF (every supply shut down), RUN (everything regulating) and SLEEP (only the switching regulator runs, in its standby form). The analog parts appear only as digital flags. These flags are a sleep request, good flags for the standby, high and low supply rails, a reference-ready flag, a thermal fault flag, an over-current trip, a soft-start-drained flag and the switching regulator's in-regulation flag. Every flag passes through a two-flop synchronizer before the block uses it.

The block wakes the supply monitors in a fixed order. It moves between modes by a fixed rule set that never goes straight from SLEEP to OFF or back. When RUN is entered, the switching regulator starts first. The termination regulator and the linear controllers start only after a soft-start window of `SS_CYCLES` clocks and a reported in-regulation. An over-current trip in RUN shuts everything down and holds it down until a supply drops out or the soft-start node is reported drained. A condition code for each output pin is derived from the mode.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, and whenever the synchronized reference-ready flag is low, the mode is OFF (code 0), the standby monitor and current reference enables are low, and no regulator is enabled.
- R2: The standby monitor and current reference enables follow the synchronized reference-ready flag. The rail monitor enable is high only when reference-ready and standby-good are both high. Rail good flags count only while the rail monitor is enabled.
- R3: OFF moves to RUN (code 1) when the sleep request is low, both rail good flags count as good and no over-current fault is latched.
- R4: RUN moves to SLEEP (code 2) on a rising edge of the synchronized sleep request. SLEEP moves to RUN when the sleep request is low and both rails are good.
- R5: RUN moves to OFF when the sleep request is low and either rail is not good. SLEEP never moves to OFF, and OFF never moves to SLEEP, except by the thermal or reference rules. Every other input combination keeps the mode.
- R6: The switching regulator enable is high in RUN and SLEEP. The termination and linear enables are high only in RUN, and only once the switching regulator has been enabled for `SS_CYCLES` clocks and has reported in-regulation. After that they stay high until RUN is left.
- R7: Pin codes are NORMAL=0, STANDBY=1, HIZ=2, LOW=3. The switching output is NORMAL/STANDBY/HIZ and its gate drive is NORMAL/STANDBY/LOW in RUN/SLEEP/OFF. The termination output is NORMAL when its enable is high and HIZ otherwise. Each linear gate drive is NORMAL when enabled and LOW otherwise.
- R8: A synchronized thermal fault forces OFF from any mode and holds it there. Once the fault clears, the normal OFF-to-RUN rule applies again.
- R9: An over-current trip while in RUN forces OFF and sets a latch that blocks RUN. The latch clears when the standby, high or low good flag is low, or when the soft-start-drained flag is high. If a trip and a sleep rising edge arrive in the same cycle, the trip wins.
- R10: An input change takes effect on the mode at the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep request, high asks for SLEEP |
| stby_ok | input | 1 | Standby supply good |
| hi_rail_ok | input | 1 | High rail supply good |
| lo_rail_ok | input | 1 | Low rail supply good |
| ref_ready | input | 1 | Internal reference in regulation |
| therm_hot | input | 1 | Thermal fault, already hysteretic |
| oc_trip | input | 1 | Switching regulator over-current |
| ss_drained | input | 1 | Soft-start node discharged externally |
| sw_in_reg | input | 1 | Switching regulator in regulation |
| mode_o | output | 2 | Mode code: 0 OFF, 1 RUN, 2 SLEEP |
| stby_mon_en | output | 1 | Standby supply monitor enable |
| iref_en | output | 1 | Current reference enable |
| rail_mon_en | output | 1 | High and low rail monitor enable |
| sw_en | output | 1 | Switching regulator soft-start enable |
| term_en | output | 1 | Termination regulator enable |
| lin_en | output | NUM_LIN | Linear controller enables |
| sw_pin | output | 2 | Switching output condition code |
| sw_gate | output | 2 | Switching gate drive condition code |
| term_pin | output | 2 | Termination output condition code |
| lin_gate | output | 2*NUM_LIN | Linear gate drive condition codes, two bits each |

## Verification
The two functions that can fall in one cycle are the over-current shutdown and the sleep entry. In RUN, the bench drives the trip and the rising sleep request on the same negative edge, so both reach the state logic through the synchronizers on the same clock. The mode must then read OFF, not SLEEP, and must stay OFF with all rails good until the soft-start-drained flag clears the latch. A behavioural model of the mode rules, run beside the design, judges every cycle of this and all other sequences.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [1:0] {
    M_OFF   = 2'd0,
    M_RUN   = 2'd1,
    M_SLEEP = 2'd2
  } pwr_mode_t;

  typedef enum logic [1:0] {
    PC_NORMAL  = 2'd0,
    PC_STANDBY = 2'd1,
    PC_HIZ     = 2'd2,
    PC_LOW     = 2'd3
  } pin_cond_t;

  // positions of the flags inside the synchronizer bundle
  localparam int IX_SLEEP = 0;
  localparam int IX_STBY  = 1;
  localparam int IX_HI    = 2;
  localparam int IX_LO    = 3;
  localparam int IX_REF   = 4;
  localparam int IX_THERM = 5;
  localparam int IX_OC    = 6;
  localparam int IX_SSD   = 7;
  localparam int IX_INREG = 8;
  localparam int N_FLAGS  = 9;

endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d[i]};
    end
    assign q[i] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
  import pms_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_ok,
  input  logic      therm,
  input  logic      sleep_s,
  input  logic      hi_ok,     // gated by rail monitor enable
  input  logic      lo_ok,
  input  logic      stby_raw,  // ungated, for latch release
  input  logic      hi_raw,
  input  logic      lo_raw,
  input  logic      oc,
  input  logic      ss_dis,
  output pwr_mode_t mode
);

  pwr_mode_t mode_q, mode_d;
  logic      sleep_d_q;
  logic      oc_lat_q, oc_lat_d;
  logic      sleep_rise, rails_ok, supply_drop;

  assign sleep_rise  = sleep_s & ~sleep_d_q;
  assign rails_ok    = hi_ok & lo_ok;
  assign supply_drop = ~stby_raw | ~hi_raw | ~lo_raw;

  always_comb begin
    mode_d = mode_q;
    if (!ref_ok || therm) begin
      mode_d = M_OFF;
    end else begin
      case (mode_q)
        M_OFF:   if (!sleep_s && rails_ok && !oc_lat_q) mode_d = M_RUN;
        M_RUN: begin
          if (oc)                          mode_d = M_OFF;
          else if (sleep_rise)             mode_d = M_SLEEP;
          else if (!sleep_s && !rails_ok)  mode_d = M_OFF;
        end
        M_SLEEP: if (!sleep_s && rails_ok) mode_d = M_RUN;
        default: mode_d = M_OFF;
      endcase
    end
  end

  always_comb begin
    oc_lat_d = oc_lat_q;
    if (mode_q == M_RUN && oc)      oc_lat_d = 1'b1;
    else if (ss_dis || supply_drop) oc_lat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_OFF;
      sleep_d_q <= 1'b0;
      oc_lat_q  <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      sleep_d_q <= sleep_s;
      oc_lat_q  <= oc_lat_d;
    end
  end

  assign mode = mode_q;

  // R5: no direct move between SLEEP and OFF unless thermal or reference loss
  p_no_sleep_to_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SLEEP && ref_ok && !therm) |=> (mode_q != M_OFF));
  p_no_off_to_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF) |=> (mode_q != M_SLEEP));
  // R8: thermal fault forces OFF
  p_therm_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    therm |=> (mode_q == M_OFF));
  // R9: latched fault blocks RUN
  p_oc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_lat_q && mode_q == M_OFF) |=> (mode_q == M_OFF));
  // R9: trip in RUN never yields SLEEP
  p_oc_beats_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && oc) |=> (mode_q == M_OFF));

endmodule

// File: rtl/pms_stagger.sv
module pms_stagger
  import pms_pkg::*;
#(
  parameter int SS_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  pwr_mode_t mode,
  input  logic      in_reg,
  output logic      sw_en,
  output logic      late_en
);

  localparam int CW = $clog2(SS_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tl_q, tl_d;
  logic          ss_done;

  assign ss_done = (cnt_q == CW'(SS_CYCLES));

  always_comb begin
    cnt_d = cnt_q;
    if (mode == M_OFF)  cnt_d = '0;
    else if (!ss_done)  cnt_d = cnt_q + 1'b1;
    tl_d = (mode == M_RUN) && (tl_q || (ss_done && in_reg));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tl_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tl_q  <= tl_d;
    end
  end

  assign sw_en   = (mode != M_OFF);
  assign late_en = tl_q && (mode == M_RUN);

  // R6: late regulators start only after in-regulation was seen
  p_late_after_inreg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_en) |-> $past(in_reg));

endmodule

// File: rtl/pms_pin_map.sv
module pms_pin_map
  import pms_pkg::*;
#(
  parameter int NUM_LIN = 2
) (
  input  pwr_mode_t              mode,
  input  logic                   late_en,
  output logic [1:0]             sw_pin,
  output logic [1:0]             sw_gate,
  output logic [1:0]             term_pin,
  output logic [2*NUM_LIN-1:0]   lin_gate
);

  always_comb begin
    case (mode)
      M_RUN: begin
        sw_pin  = PC_NORMAL;
        sw_gate = PC_NORMAL;
      end
      M_SLEEP: begin
        sw_pin  = PC_STANDBY;
        sw_gate = PC_STANDBY;
      end
      default: begin
        sw_pin  = PC_HIZ;
        sw_gate = PC_LOW;
      end
    endcase
  end

  assign term_pin = late_en ? PC_NORMAL : PC_HIZ;

  for (genvar i = 0; i < NUM_LIN; i++) begin : g_lin
    assign lin_gate[2*i +: 2] = late_en ? PC_NORMAL : PC_LOW;
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int SS_CYCLES = 16,
  parameter int NUM_LIN   = 2,
  parameter int SYNC_LEN  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleep_req,
  input  logic                 stby_ok,
  input  logic                 hi_rail_ok,
  input  logic                 lo_rail_ok,
  input  logic                 ref_ready,
  input  logic                 therm_hot,
  input  logic                 oc_trip,
  input  logic                 ss_drained,
  input  logic                 sw_in_reg,
  output logic [1:0]           mode_o,
  output logic                 stby_mon_en,
  output logic                 iref_en,
  output logic                 rail_mon_en,
  output logic                 sw_en,
  output logic                 term_en,
  output logic [NUM_LIN-1:0]   lin_en,
  output logic [1:0]           sw_pin,
  output logic [1:0]           sw_gate,
  output logic [1:0]           term_pin,
  output logic [2*NUM_LIN-1:0] lin_gate
);

  logic [N_FLAGS-1:0] raw, syn;
  pwr_mode_t          mode;
  logic               late_en;

  always_comb begin
    raw           = '0;
    raw[IX_SLEEP] = sleep_req;
    raw[IX_STBY]  = stby_ok;
    raw[IX_HI]    = hi_rail_ok;
    raw[IX_LO]    = lo_rail_ok;
    raw[IX_REF]   = ref_ready;
    raw[IX_THERM] = therm_hot;
    raw[IX_OC]    = oc_trip;
    raw[IX_SSD]   = ss_drained;
    raw[IX_INREG] = sw_in_reg;
  end

  pms_sync #(.WIDTH(N_FLAGS), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  // monitor wake order: standby monitor with the reference, rails after standby
  assign stby_mon_en = syn[IX_REF];
  assign iref_en     = syn[IX_REF];
  assign rail_mon_en = syn[IX_REF] & syn[IX_STBY];

  pms_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .ref_ok(syn[IX_REF]), .therm(syn[IX_THERM]), .sleep_s(syn[IX_SLEEP]),
    .hi_ok(syn[IX_HI] & rail_mon_en), .lo_ok(syn[IX_LO] & rail_mon_en),
    .stby_raw(syn[IX_STBY]), .hi_raw(syn[IX_HI]), .lo_raw(syn[IX_LO]),
    .oc(syn[IX_OC]), .ss_dis(syn[IX_SSD]), .mode(mode)
  );

  pms_stagger #(.SS_CYCLES(SS_CYCLES)) u_stag (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_reg(syn[IX_INREG]),
    .sw_en(sw_en), .late_en(late_en)
  );

  pms_pin_map #(.NUM_LIN(NUM_LIN)) u_pins (
    .mode(mode), .late_en(late_en), .sw_pin(sw_pin), .sw_gate(sw_gate),
    .term_pin(term_pin), .lin_gate(lin_gate)
  );

  assign mode_o  = mode;
  assign term_en = late_en;
  assign lin_en  = {NUM_LIN{late_en}};

  // R7: sleep pins are standby / hi-z / low
  p_sleep_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> (sw_pin == 2'd1 && term_pin == 2'd2 &&
                          lin_gate == {NUM_LIN{2'b11}}));
  // R6: termination only runs in RUN with the switcher enabled
  p_term_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    term_en |-> (mode_o == 2'd1 && sw_en));
  // R1: losing the reference shuts everything down
  p_ref_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_mon_en |=> (mode_o == 2'd0));

endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;

  localparam int SS  = 16;
  localparam int NL  = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic sleep_req, stby_ok, hi_rail_ok, lo_rail_ok, ref_ready;
  logic therm_hot, oc_trip, ss_drained, sw_in_reg;
  logic [1:0] mode_o, sw_pin, sw_gate, term_pin;
  logic stby_mon_en, iref_en, rail_mon_en, sw_en, term_en;
  logic [NL-1:0] lin_en;
  logic [2*NL-1:0] lin_gate;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  pwr_mode_seq #(.SS_CYCLES(SS), .NUM_LIN(NL)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_ok(stby_ok),
    .hi_rail_ok(hi_rail_ok), .lo_rail_ok(lo_rail_ok), .ref_ready(ref_ready),
    .therm_hot(therm_hot), .oc_trip(oc_trip), .ss_drained(ss_drained),
    .sw_in_reg(sw_in_reg), .mode_o(mode_o), .stby_mon_en(stby_mon_en),
    .iref_en(iref_en), .rail_mon_en(rail_mon_en), .sw_en(sw_en),
    .term_en(term_en), .lin_en(lin_en), .sw_pin(sw_pin), .sw_gate(sw_gate),
    .term_pin(term_pin), .lin_gate(lin_gate)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // flag order: sleep stby hi lo ref therm oc ssd inreg
  bit [8:0] p1, p2;
  bit       m_sd, m_lat, m_tl;
  int       m_mode, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = '0; p2 = '0; m_sd = 0; m_lat = 0; m_tl = 0; m_mode = 0; m_cnt = 0;
    end else begin
      bit sl, sb, hi, lo, rf, th, oc, sd, ir, ren, rok;
      int nm; bit nl, ntl; int nc;
      {ir, sd, oc, th, rf, lo, hi, sb, sl} = p2;
      ren = rf & sb;
      rok = hi & lo & ren;
      nm = m_mode;
      if (!rf || th) nm = 0;
      else if (m_mode == 0) begin
        if (!sl && rok && !m_lat) nm = 1;
      end else if (m_mode == 1) begin
        if (oc) nm = 0;
        else if (sl && !m_sd) nm = 2;
        else if (!sl && !rok) nm = 0;
      end else begin
        if (!sl && rok) nm = 1;
      end
      nl = m_lat;
      if (m_mode == 1 && oc) nl = 1;
      else if (sd || !sb || !hi || !lo) nl = 0;
      nc = (m_mode == 0) ? 0 : ((m_cnt < SS) ? m_cnt + 1 : m_cnt);
      ntl = (m_mode == 1) && (m_tl || (m_cnt == SS && ir));
      m_mode = nm; m_lat = nl; m_cnt = nc; m_tl = ntl;
      m_sd = sl;
      p2 = p1;
      p1 = {sw_in_reg, ss_drained, oc_trip, therm_hot, ref_ready,
            lo_rail_ok, hi_rail_ok, stby_ok, sleep_req};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int te, sp, sg;
      te = (m_tl && m_mode == 1) ? 1 : 0;
      sp = (m_mode == 1) ? 0 : (m_mode == 2) ? 1 : 2;
      sg = (m_mode == 1) ? 0 : (m_mode == 2) ? 1 : 3;
      check("R4 mode", mode_o, m_mode);
      check("R2 stby_mon", stby_mon_en, p2[4]);
      check("R2 iref", iref_en, p2[4]);
      check("R2 rail_mon", rail_mon_en, p2[4] & p2[1]);
      check("R6 sw_en", sw_en, (m_mode != 0) ? 1 : 0);
      check("R6 term_en", term_en, te);
      check("R6 lin_en", lin_en, te ? 3 : 0);
      check("R7 sw_pin", sw_pin, sp);
      check("R7 sw_gate", sw_gate, sg);
      check("R7 term_pin", term_pin, te ? 0 : 2);
      check("R7 lin_gate", lin_gate, te ? 0 : 15);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; sleep_req = 0; stby_ok = 1; hi_rail_ok = 1; lo_rail_ok = 1;
    ref_ready = 0; therm_hot = 0; oc_trip = 0; ss_drained = 0; sw_in_reg = 0;
    step(3);
    check("R1 reset mode", mode_o, 0);
    check("R1 reset sw_en", sw_en, 0);
    rst_n = 1;
    step(10);
    check("R1 no reference mode", mode_o, 0);
    check("R1 no reference monitor", stby_mon_en, 0);
    stby_ok = 0; ref_ready = 1;
    step(10);
    check("R2 rail monitor waits for standby", rail_mon_en, 0);
    check("R2 mode stays off", mode_o, 0);
    stby_ok = 1;
    step(10);
    check("R3 enter run", mode_o, 1);
    step(40);
    check("R6 no late enable without in-reg", term_en, 0);
    check("R6 switcher on", sw_en, 1);
    sw_in_reg = 1;
    step(6);
    check("R6 termination on", term_en, 1);
    check("R6 linears on", lin_en, 3);
    // R10 latency on sleep entry
    sleep_req = 1;
    step(2);
    check("R10 still run after two edges", mode_o, 1);
    step(1);
    check("R10 R4 sleep on third edge", mode_o, 2);
    check("R7 sleep sw_pin", sw_pin, 1);
    check("R7 sleep term_pin", term_pin, 2);
    check("R7 sleep lin_gate", lin_gate, 15);
    hi_rail_ok = 0; sleep_req = 0;
    step(10);
    check("R5 sleep holds with rail bad", mode_o, 2);
    hi_rail_ok = 1;
    step(10);
    check("R4 sleep back to run", mode_o, 1);
    lo_rail_ok = 0;
    step(10);
    check("R5 run to off on rail loss", mode_o, 0);
    check("R7 off sw_pin", sw_pin, 2);
    check("R7 off sw_gate", sw_gate, 3);
    lo_rail_ok = 1;
    step(10);
    check("R3 run again", mode_o, 1);
    sleep_req = 1;
    step(10);
    therm_hot = 1;
    step(10);
    check("R8 thermal forces off from sleep", mode_o, 0);
    sleep_req = 0;
    step(10);
    check("R8 stays off while hot", mode_o, 0);
    therm_hot = 0;
    step(10);
    check("R8 resumes run", mode_o, 1);
    step(30);
    oc_trip = 1; step(1); oc_trip = 0;
    step(25);
    check("R9 trip latches off", mode_o, 0);
    ss_drained = 1; step(1); ss_drained = 0;
    step(10);
    check("R9 drained releases", mode_o, 1);
    oc_trip = 1; step(1); oc_trip = 0;
    step(10);
    check("R9 second trip", mode_o, 0);
    hi_rail_ok = 0; step(5); hi_rail_ok = 1;
    step(10);
    check("R9 supply recycle releases", mode_o, 1);
    // collision: trip and sleep edge in one cycle
    oc_trip = 1; sleep_req = 1; step(1); oc_trip = 0;
    step(10);
    check("R9 trip beats sleep", mode_o, 0);
    sleep_req = 0;
    step(20);
    check("R9 still latched", mode_o, 0);
    ss_drained = 1; step(1); ss_drained = 0;
    step(10);
    check("R9 run after release", mode_o, 1);
    ref_ready = 0;
    step(10);
    check("R1 reference loss mode", mode_o, 0);
    check("R1 reference loss iref", iref_en, 0);
    step(5);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule